// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block sits in the execute stage of a small 16-bit processor with a 12-bit program counter. A compare step hands it two operands. It compares them as unsigned numbers and stores the result as a zero flag and a carry flag. These flags stay in place until the next compare.

The decoder presents a jump kind and a signed 12-bit offset. The block decides from the stored flags whether the jump is taken. It then forms the next program counter: either the sequential address, or that address plus the offset.

The block owns the program counter register. The register moves only when the control sequence enables a PC write.

Top module: `branch_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, both flags and the program counter are cleared to 0.
- R2: A rising edge with `cmp_we` high and `cmp_a == cmp_b` leaves `flag_z`=1 and `flag_c`=0.
- R3: The comparison is unsigned over 16 bits. With `cmp_a > cmp_b` the flags become Z=0, C=0. With `cmp_a < cmp_b` they become Z=0, C=1. Z and C are never both 1.
- R4: At an edge with `cmp_we` low the flags keep their values, whatever the operands are.
- R5: Jump kind encoding on `jmp_kind`: 0 means no jump and is never taken. 1 is an unconditional jump and is always taken. 7 is reserved and never taken.
- R6: Kind 2 (equal) is taken when Z=1 and C=0. Kind 3 (above) is taken when Z=0 and C=0. Kind 4 (below) is taken when Z=0 and C=1.
- R7: Kind 5 (above-or-equal) is taken when C=0. Kind 6 (below-or-equal) is taken when C=1 or Z=1.
- R8: `pc_next` is `pc_cur + 1` when not taken. When taken it is `pc_cur + 1 + jmp_off`, with `jmp_off` read as two's complement. Both sums wrap modulo 4096.
- R9: `pc_cur` loads `pc_next` at an edge with `pc_we` high and holds at an edge with `pc_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_a | input | 16 | First compare operand |
| cmp_b | input | 16 | Second compare operand |
| cmp_we | input | 1 | Strobe to update the flags from the compare |
| jmp_kind | input | 3 | Jump kind code (see R5 to R7) |
| jmp_off | input | 12 | Signed jump offset |
| pc_we | input | 1 | Program counter write enable |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| br_taken | output | 1 | Current jump kind is taken under the stored flags |
| pc_cur | output | 12 | Program counter register |
| pc_next | output | 12 | Address the PC will load on the next write |

## Verification
Operand pairs are chosen to cover each compare outcome, plus pairs with the top bit set (0x8000 against 0x7FFF, 0xFFFF against 0). These pairs separate an unsigned compare from a signed one. Every jump kind, including the reserved code, is applied under each of the three reachable flag states. This sweep tells the strict predicates apart from the inclusive ones. Forward, backward and wrapping offsets, and a step from 0xFFF to 0, separate a correct modulo-4096 target from an unsigned or truncated offset. Stimulus with the enable low shows that the flags and the PC hold.

// File: rtl/brres_pkg.sv
package brres_pkg;

    localparam int PC_W   = 12;
    localparam int OPND_W = 16;
    localparam int KIND_W = 3;
    localparam int N_KIND = 1 << KIND_W;

    typedef enum logic [KIND_W-1:0] {
        JK_NONE   = 3'd0,
        JK_ALWAYS = 3'd1,
        JK_EQ     = 3'd2,
        JK_ABOVE  = 3'd3,
        JK_BELOW  = 3'd4,
        JK_AE     = 3'd5,
        JK_BE     = 3'd6,
        JK_RSVD   = 3'd7
    } jkind_e;

    typedef struct packed {
        logic zf;
        logic cf;
    } cflags_t;

    // Predicate of one jump kind over the stored flags
    function automatic logic cond_holds(input jkind_e k, input cflags_t f);
        unique case (k)
            JK_ALWAYS: return 1'b1;
            JK_EQ:     return  f.zf && !f.cf;
            JK_ABOVE:  return !f.zf && !f.cf;
            JK_BELOW:  return !f.zf &&  f.cf;
            JK_AE:     return !f.cf;
            JK_BE:     return  f.cf ||  f.zf;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmp_flag_reg.sv
module cmp_flag_reg
    import brres_pkg::*;
#(
    parameter int W = OPND_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         we,
    output cflags_t      flags
);
    cflags_t cmp_res;

    // Unsigned compare: equal -> Z, below -> C, above -> neither
    always_comb begin
        cmp_res.zf = (a == b);
        cmp_res.cf = (a < b);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (we)
            flags <= cmp_res;
    end
endmodule

// File: rtl/branch_cond.sv
module branch_cond
    import brres_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  cflags_t           flags,
    output logic              taken
);
    logic [N_KIND-1:0] pred;

    // One predicate per kind code, then pick the active one
    for (genvar k = 0; k < N_KIND; k++) begin : g_pred
        assign pred[k] = cond_holds(jkind_e'(k), flags);
    end

    assign taken = pred[kind];
endmodule

// File: rtl/pc_unit.sv
module pc_unit
    import brres_pkg::*;
#(
    parameter int AW = PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          taken,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] pc_nxt
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] seq_addr;
    logic [AW-1:0] tgt_addr;

    // Offset is relative to the following instruction; sums wrap at 2**AW
    assign seq_addr = pc + ONE;
    assign tgt_addr = seq_addr + off;
    assign pc_nxt   = taken ? tgt_addr : seq_addr;

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (we)
            pc <= pc_nxt;
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brres_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int DW = OPND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     cmp_a,
    input  logic [DW-1:0]     cmp_b,
    input  logic              cmp_we,
    input  logic [KIND_W-1:0] jmp_kind,
    input  logic [AW-1:0]     jmp_off,
    input  logic              pc_we,
    output logic              flag_z,
    output logic              flag_c,
    output logic              br_taken,
    output logic [AW-1:0]     pc_cur,
    output logic [AW-1:0]     pc_next
);
    cflags_t flags;

    cmp_flag_reg #(.W(DW)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .a     (cmp_a),
        .b     (cmp_b),
        .we    (cmp_we),
        .flags (flags)
    );

    branch_cond u_cond (
        .kind  (jmp_kind),
        .flags (flags),
        .taken (br_taken)
    );

    pc_unit #(.AW(AW)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .we     (pc_we),
        .taken  (br_taken),
        .off    (jmp_off),
        .pc     (pc_cur),
        .pc_nxt (pc_next)
    );

    assign flag_z = flags.zf;
    assign flag_c = flags.cf;
endmodule

// File: rtl/brres_chk.sv
module brres_chk
    import brres_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int DW = OPND_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DW-1:0]     cmp_a,
    input logic [DW-1:0]     cmp_b,
    input logic              cmp_we,
    input logic [KIND_W-1:0] jmp_kind,
    input logic [AW-1:0]     jmp_off,
    input logic              pc_we,
    input logic              flag_z,
    input logic              flag_c,
    input logic              br_taken,
    input logic [AW-1:0]     pc_cur,
    input logic [AW-1:0]     pc_next
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!flag_z && !flag_c && pc_cur == '0));

    assert_equal_flags_R2: assert property (@(posedge clk) disable iff (rst)
        (cmp_we && cmp_a == cmp_b) |=> (flag_z && !flag_c));

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(flag_z && flag_c));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cmp_we |=> $stable({flag_z, flag_c}));

    assert_none_never_R5: assert property (@(posedge clk) disable iff (rst)
        (jmp_kind == JK_NONE || jmp_kind == JK_RSVD) |-> !br_taken);

    assert_always_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (jmp_kind == JK_ALWAYS) |-> br_taken);

    assert_seq_step_R8: assert property (@(posedge clk) disable iff (rst)
        (pc_we && !br_taken) |=> pc_cur == AW'($past(pc_cur) + AW'(1)));

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_cur));
endmodule

bind branch_resolver brres_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_branch_resolver.sv
`timescale 1ns/1ps
module sim_branch_resolver;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cmp_a, cmp_b;
    logic        cmp_we;
    logic [2:0]  jmp_kind;
    logic [11:0] jmp_off;
    logic        pc_we;
    logic        flag_z, flag_c, br_taken;
    logic [11:0] pc_cur, pc_next;

    int n_vec = 0;
    int n_bad = 0;
    logic        m_z, m_c;
    logic [11:0] m_pc;

    always #2.5 clk = ~clk;

    branch_resolver u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_taken(input logic [2:0] k, input logic z, input logic c);
        case (k)
            3'd1: return 1'b1;
            3'd2: return z & ~c;
            3'd3: return ~z & ~c;
            3'd4: return ~z & c;
            3'd5: return ~c;
            3'd6: return c | z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_cmp(input logic [15:0] a, input logic [15:0] b);
        cmp_a = a; cmp_b = b; cmp_we = 1'b1;
        tick();
        cmp_we = 1'b0;
        m_z = (a == b);
        m_c = (a < b);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        chk("R1 zf", flag_z, 0);
        chk("R1 cf", flag_c, 0);
        chk("R1 pc", pc_cur, 0);
        rst = 1'b0;
        m_z = 0; m_c = 0; m_pc = 0;
    endtask

    task automatic t_compare();
        logic [15:0] pa [6] = '{16'h0005, 16'h0009, 16'h0003, 16'h0000, 16'hFFFF, 16'h8000};
        logic [15:0] pb [6] = '{16'h0005, 16'h0003, 16'h0009, 16'hFFFF, 16'h0000, 16'h7FFF};
        for (int i = 0; i < 6; i++) begin
            do_cmp(pa[i], pb[i]);
            chk((pa[i] == pb[i]) ? "R2 zf" : "R3 zf", flag_z, m_z);
            chk((pa[i] == pb[i]) ? "R2 cf" : "R3 cf", flag_c, m_c);
        end
    endtask

    task automatic t_hold();
        do_cmp(16'h0001, 16'h0002);
        for (int i = 0; i < 4; i++) begin
            cmp_a = 16'(i * 7); cmp_b = 16'(i * 7);
            tick();
            chk("R4 zf", flag_z, m_z);
            chk("R4 cf", flag_c, m_c);
        end
    endtask

    task automatic t_conditions();
        logic [15:0] sa [3] = '{16'h0010, 16'h0020, 16'h0010};
        logic [15:0] sb [3] = '{16'h0010, 16'h0010, 16'h0020};
        pc_we = 1'b0;
        for (int s = 0; s < 3; s++) begin
            do_cmp(sa[s], sb[s]);
            for (int k = 0; k < 8; k++) begin
                jmp_kind = 3'(k);
                #1;
                chk((k < 2 || k == 7) ? "R5 taken" : (k < 5 ? "R6 taken" : "R7 taken"),
                    br_taken, exp_taken(3'(k), m_z, m_c));
            end
        end
        jmp_kind = 3'd0;
    endtask

    task automatic step(input logic [2:0] k, input logic [11:0] off, input logic we);
        logic t;
        logic [11:0] nx;
        jmp_kind = k; jmp_off = off; pc_we = we;
        #1;
        t  = exp_taken(k, m_z, m_c);
        nx = m_pc + 12'd1 + (t ? off : 12'd0);
        chk("R8 next", pc_next, nx);
        tick();
        if (we) m_pc = nx;
        chk("R9 pc", pc_cur, m_pc);
        pc_we = 1'b0;
    endtask

    task automatic t_pc();
        do_cmp(16'h0004, 16'h0004);
        step(3'd0, 12'd0, 1'b1);
        step(3'd1, 12'd3, 1'b1);
        step(3'd2, -12'sd5, 1'b1);
        step(3'd3, 12'd9, 1'b1);
        step(3'd1, 12'd100, 1'b0);
        step(3'd1, 12'hFF0, 1'b1);
        step(3'd0, 12'd0, 1'b1);
        step(3'd1, 12'd7, 1'b1);
        step(3'd1, 12'hFF0, 1'b1);
        step(3'd1, (12'hFFF - m_pc - 12'd1), 1'b1);
        chk("R8 at top", pc_cur, 12'hFFF);
        step(3'd4, 12'd1, 1'b1);
        chk("R8 wrap", pc_cur, 12'h000);
    endtask

    initial begin
        cmp_a = 0; cmp_b = 0; cmp_we = 0; jmp_kind = 0; jmp_off = 0; pc_we = 0; rst = 1;
        @(negedge clk);
        t_reset();
        t_compare();
        t_hold();
        t_conditions();
        t_pc();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule